// File: doc/BRIEF.md
# Word Stack Push/Pop Engine

This block moves 16-bit words between a register set and a byte-wide stack memory. It owns the stack pointer and forms every physical byte address from a 16-bit segment value and that pointer. A command starts a push of one word, a pop of one word into a chosen destination, a save of all eight general registers, or a restore of all of them. Each word takes two single-byte memory cycles, so one push or one pop finishes two clocks after it is accepted.

A host issues a command with `cmd_valid` while `busy` is low. Push data comes in on `push_data`. A save-all takes a snapshot of `gpr_in` at acceptance. Popped words leave on `wr_data` together with `wr_en` and the destination code on `wr_sel`. A pop that targets the code segment, or an unused destination code, is refused and flagged on `illegal_dst`.

The controller has six states:
- ST_IDLE waits for a command. From it, a push or save-all goes to ST_WR_HI, a legal pop or a restore-all goes to ST_RD_LO, and a refused pop goes to ST_FAULT.
- ST_WR_HI writes the upper byte and always goes to ST_WR_LO.
- ST_WR_LO writes the lower byte and updates the pointer. It returns to ST_IDLE after the last word and loops to ST_WR_HI otherwise.
- ST_RD_LO reads the lower byte and always goes to ST_RD_HI.
- ST_RD_HI reads the upper byte, delivers the word and updates the pointer. It returns to ST_IDLE after the last word and loops to ST_RD_LO otherwise.
- ST_FAULT raises the flag for one cycle and goes back to ST_IDLE.

Top module: `wsk_engine`

## Requirements
- R1: After reset `sp` equals the parameter SP_RESET (default 0xFFFE), and `busy`, `done`, `illegal_dst`, `mem_we`, `mem_re` and `wr_en` are all low.
- R2: A push (cmd_op=0) writes bits 15:8 to offset SP-1 in the first cycle after acceptance and bits 7:0 to offset SP-2 in the second cycle. `done` is high in that second cycle, and afterwards SP has dropped by 2.
- R3: A pop (cmd_op=1) reads offset SP in the first cycle after acceptance and offset SP+1 in the second cycle. In that second cycle `wr_en` is high, `wr_sel` equals `cmd_dst`, `wr_data` is {byte at SP+1, byte at SP} and `done` is high. Afterwards SP has risen by 2.
- R4: Every memory access uses `mem_addr` = (ss × 16 + offset) mod 2^20, where ss is the segment value on the `ss` input.
- R5: Words come back in last-in first-out order. Pushing three words and then popping three times returns them in reverse order.
- R6: A pop to destination 9 (code segment) or to a code from 12 to 15 makes no memory access and no register write and leaves SP unchanged. It raises `illegal_dst` for exactly the first cycle after acceptance. Codes 0–7 select AX, CX, DX, BX, SP, BP, SI, DI, and codes 8, 10 and 11 select the other segment registers.
- R7: A save-all (cmd_op=2) pushes gpr_in slots 0,1,2,3 (AX, CX, DX, BX), then the SP value from before the command, then slots 5,6,7 (BP, SI, DI), in that order. The eight words take 16 back-to-back cycles and `done` is high only in the last one.
- R8: A restore-all (cmd_op=3) pops eight words into destinations 7,6,5,4,3,2,1,0 in that order. It drops the word for destination 4 (no `wr_en`), ends with SP 16 higher, and raises `done` only in its last cycle.
- R9: All SP arithmetic and offset sums wrap modulo 65536.
- R10: A single pop to destination 4 loads SP with the popped word instead of adding 2.
- R11: `cmd_valid` while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request, taken when not busy |
| cmd_op | input | 2 | 0 push, 1 pop, 2 save-all, 3 restore-all |
| cmd_dst | input | 4 | Pop destination code |
| push_data | input | 16 | Word for a single push |
| gpr_in | input | 128 | General registers, slot i at bits 16i+15:16i |
| ss | input | 16 | Stack segment value |
| mem_rdata | input | 8 | Read byte, valid in the cycle of mem_re |
| busy | output | 1 | Command in progress |
| done | output | 1 | Last cycle of a push, pop or sequence |
| illegal_dst | output | 1 | Refused pop destination |
| mem_we | output | 1 | Byte write strobe |
| mem_re | output | 1 | Byte read strobe |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 8 | Byte to write |
| wr_en | output | 1 | Register write strobe for a popped word |
| wr_sel | output | 4 | Destination code of the popped word |
| wr_data | output | 16 | Popped word |
| sp | output | 16 | Current stack pointer |

## Verification
Three distinct words are pushed and popped in turn. This shows last-in first-out order and the high-then-low byte placement, which a swapped byte order or a wrong pointer step would break. The pointer is then loaded through a pop to SP so that a push crosses offset zero. The segment is also moved high enough that the physical sum overflows 20 bits, which separates correct modulo arithmetic from carries into the segment. Save-all followed by restore-all checks the slot order and the skipped SP slot. Refused destinations and a mid-command request check that nothing moves.

// File: rtl/wsk_pkg.sv
package wsk_pkg;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int NGPR   = 8;
    localparam int SEL_W  = 4;
    localparam int CNT_W  = $clog2(NGPR);

    typedef enum logic [1:0] {
        OP_PUSH    = 2'd0,
        OP_POP     = 2'd1,
        OP_PUSHALL = 2'd2,
        OP_POPALL  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_HI,
        ST_WR_LO,
        ST_RD_LO,
        ST_RD_HI,
        ST_FAULT
    } st_e;

    localparam logic [SEL_W-1:0] SEL_SP   = 4'd4;
    localparam logic [SEL_W-1:0] SEL_CS   = 4'd9;
    localparam logic [SEL_W-1:0] SEL_LAST = 4'd11;

    function automatic logic dst_ok(input logic [SEL_W-1:0] d);
        return (d <= SEL_LAST) && (d != SEL_CS);
    endfunction
endpackage

// File: rtl/wsk_addr.sv
module wsk_addr #(
    parameter int SEG_W = 16,
    parameter int OFS_W = 16,
    parameter int SHIFT = 4
) (
    input  logic [SEG_W-1:0]       seg,
    input  logic [OFS_W-1:0]       ofs,
    input  logic signed [2:0]      delta,
    output logic [SEG_W+SHIFT-1:0] phys
);
    localparam int PHYS_W = SEG_W + SHIFT;

    logic [OFS_W-1:0]  ofs_eff;
    logic [PHYS_W-1:0] seg_base;
    logic [PHYS_W-1:0] ofs_ext;

    // offset sum wraps inside the segment width
    assign ofs_eff  = ofs + OFS_W'(delta);
    assign seg_base = {seg, {SHIFT{1'b0}}};
    assign ofs_ext  = PHYS_W'(ofs_eff);
    assign phys     = seg_base + ofs_ext;
endmodule

// File: rtl/wsk_ctrl.sv
module wsk_ctrl
    import wsk_pkg::*;
#(
    parameter logic [WORD_W-1:0] SP_RESET = 16'hFFFE
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_valid,
    input  logic [1:0]             cmd_op,
    input  logic [SEL_W-1:0]       cmd_dst,
    input  logic [WORD_W-1:0]      push_data,
    input  logic [NGPR*WORD_W-1:0] gpr_in,
    input  logic [BYTE_W-1:0]      mem_rdata,
    output logic                   busy,
    output logic                   done,
    output logic                   illegal_dst,
    output logic                   mem_we,
    output logic                   mem_re,
    output logic signed [2:0]      addr_delta,
    output logic [BYTE_W-1:0]      mem_wdata,
    output logic                   wr_en,
    output logic [SEL_W-1:0]       wr_sel,
    output logic [WORD_W-1:0]      wr_data,
    output logic [WORD_W-1:0]      sp
);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(NGPR - 1);
    localparam logic [CNT_W-1:0] CNT_SP  = CNT_W'(SEL_SP);

    st_e                state_q, state_d;
    op_e                op_q;
    logic [SEL_W-1:0]   dst_q;
    logic [WORD_W-1:0]  pushw_q;
    logic [WORD_W-1:0]  sp_q;
    logic [WORD_W-1:0]  sp_save_q;
    logic [BYTE_W-1:0]  lo_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               multi_q;
    logic [WORD_W-1:0]  snap_q [NGPR];
    logic [WORD_W-1:0]  gpr_arr [NGPR];
    logic [WORD_W-1:0]  cur_word;
    logic               last;
    logic               accept;
    op_e                cmd_op_e;

    for (genvar g = 0; g < NGPR; g++) begin : g_unpack
        assign gpr_arr[g] = gpr_in[g*WORD_W +: WORD_W];
    end

    assign cmd_op_e = op_e'(cmd_op);
    assign accept   = (state_q == ST_IDLE) && cmd_valid;
    assign last     = !multi_q || ((op_q == OP_PUSHALL) ? (cnt_q == CNT_TOP)
                                                        : (cnt_q == '0));
    assign cur_word = !multi_q ? pushw_q
                    : (cnt_q == CNT_SP) ? sp_save_q : snap_q[cnt_q];
    assign sp       = sp_q;
    assign busy     = (state_q != ST_IDLE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    unique case (cmd_op_e)
                        OP_PUSH, OP_PUSHALL: state_d = ST_WR_HI;
                        OP_POP:    state_d = dst_ok(cmd_dst) ? ST_RD_LO : ST_FAULT;
                        OP_POPALL: state_d = ST_RD_LO;
                        default:   state_d = ST_IDLE;
                    endcase
                end
            end
            ST_WR_HI: state_d = ST_WR_LO;
            ST_WR_LO: state_d = last ? ST_IDLE : ST_WR_HI;
            ST_RD_LO: state_d = ST_RD_HI;
            ST_RD_HI: state_d = last ? ST_IDLE : ST_RD_LO;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            op_q      <= OP_PUSH;
            dst_q     <= '0;
            pushw_q   <= '0;
            sp_q      <= SP_RESET;
            sp_save_q <= '0;
            lo_q      <= '0;
            cnt_q     <= '0;
            multi_q   <= 1'b0;
            for (int i = 0; i < NGPR; i++) snap_q[i] <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_q      <= cmd_op_e;
                dst_q     <= cmd_dst;
                pushw_q   <= push_data;
                sp_save_q <= sp_q;
                multi_q   <= (cmd_op_e == OP_PUSHALL) || (cmd_op_e == OP_POPALL);
                cnt_q     <= (cmd_op_e == OP_POPALL) ? CNT_TOP : '0;
                for (int i = 0; i < NGPR; i++) snap_q[i] <= gpr_arr[i];
            end
            if (state_q == ST_RD_LO) lo_q <= mem_rdata;
            if (state_q == ST_WR_LO) begin
                sp_q <= sp_q - WORD_W'(2);
                if (multi_q) cnt_q <= cnt_q + CNT_W'(1);
            end
            if (state_q == ST_RD_HI) begin
                if (!multi_q && dst_q == SEL_SP) sp_q <= {mem_rdata, lo_q};
                else                             sp_q <= sp_q + WORD_W'(2);
                if (multi_q) cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    // outputs per state
    always_comb begin
        done        = 1'b0;
        illegal_dst = 1'b0;
        mem_we      = 1'b0;
        mem_re      = 1'b0;
        addr_delta  = 3'sd0;
        mem_wdata   = '0;
        wr_en       = 1'b0;
        wr_sel      = '0;
        wr_data     = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WR_HI: begin
                mem_we     = 1'b1;
                addr_delta = -3'sd1;
                mem_wdata  = cur_word[WORD_W-1:BYTE_W];
            end
            ST_WR_LO: begin
                mem_we     = 1'b1;
                addr_delta = -3'sd2;
                mem_wdata  = cur_word[BYTE_W-1:0];
                done       = last;
            end
            ST_RD_LO: begin
                mem_re     = 1'b1;
                addr_delta = 3'sd0;
            end
            ST_RD_HI: begin
                mem_re     = 1'b1;
                addr_delta = 3'sd1;
                wr_en      = multi_q ? (cnt_q != CNT_SP) : 1'b1;
                wr_sel     = multi_q ? SEL_W'(cnt_q) : dst_q;
                wr_data    = {mem_rdata, lo_q};
                done       = last;
            end
            ST_FAULT: illegal_dst = 1'b1;
            default: ;
        endcase
    end

    AST_PUSH_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WR_LO) |=> (sp_q == $past(sp_q) - 16'd2)); // R2

    AST_POP_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_HI && !(!multi_q && dst_q == SEL_SP))
        |=> (sp_q == $past(sp_q) + 16'd2)); // R3

    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_dst |-> (!mem_we && !mem_re && !wr_en)); // R6

    AST_FAULT_SP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_dst |=> (sp_q == $past(sp_q))); // R6

    AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_dst |=> !illegal_dst); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && !illegal_dst) |=> busy); // R11

    AST_RESTORE_SKIP_SP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && multi_q) |-> (wr_sel != SEL_SP)); // R8
endmodule

// File: rtl/wsk_engine.sv
module wsk_engine
    import wsk_pkg::*;
#(
    parameter logic [15:0] SP_RESET = 16'hFFFE
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic [1:0]     cmd_op,
    input  logic [3:0]     cmd_dst,
    input  logic [15:0]    push_data,
    input  logic [127:0]   gpr_in,
    input  logic [15:0]    ss,
    input  logic [7:0]     mem_rdata,
    output logic           busy,
    output logic           done,
    output logic           illegal_dst,
    output logic           mem_we,
    output logic           mem_re,
    output logic [19:0]    mem_addr,
    output logic [7:0]     mem_wdata,
    output logic           wr_en,
    output logic [3:0]     wr_sel,
    output logic [15:0]    wr_data,
    output logic [15:0]    sp
);
    logic signed [2:0] delta;

    wsk_ctrl #(.SP_RESET(SP_RESET)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_dst     (cmd_dst),
        .push_data   (push_data),
        .gpr_in      (gpr_in),
        .mem_rdata   (mem_rdata),
        .busy        (busy),
        .done        (done),
        .illegal_dst (illegal_dst),
        .mem_we      (mem_we),
        .mem_re      (mem_re),
        .addr_delta  (delta),
        .mem_wdata   (mem_wdata),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .sp          (sp)
    );

    wsk_addr #(.SEG_W(16), .OFS_W(WORD_W), .SHIFT(4)) u_addr (
        .seg   (ss),
        .ofs   (sp),
        .delta (delta),
        .phys  (mem_addr)
    );
endmodule

// File: tb/tb_wsk_engine.sv
module tb_wsk_engine;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic [1:0]   cmd_op = '0;
    logic [3:0]   cmd_dst = '0;
    logic [15:0]  push_data = '0;
    logic [127:0] gpr_in = '0;
    logic [15:0]  ss = 16'h0100;
    logic [7:0]   mem_rdata;
    logic         busy, done, illegal_dst, mem_we, mem_re, wr_en;
    logic [19:0]  mem_addr;
    logic [7:0]   mem_wdata;
    logic [3:0]   wr_sel;
    logic [15:0]  wr_data, sp;

    always #10 clk = ~clk;

    wsk_engine dut (.*);

    logic [7:0] mem     [4096];
    logic [7:0] exp_mem [4096];
    assign mem_rdata = mem[mem_addr[11:0]];
    always @(posedge clk) if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;

    typedef struct {
        bit          bsy, we, re, wen, dn, ill;
        logic [19:0] addr;
        logic [7:0]  wd;
        logic [3:0]  sel;
        logic [15:0] wdat, spv;
        int          req;
    } rec_t;

    rec_t        q[$];
    logic [15:0] msp = 16'hFFFE;
    int          checks = 0, failures = 0;
    bit          mon_on = 1'b0, finished = 1'b0;
    logic [15:0] last_pop = '0;

    task automatic chk(input bit ok, input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [19:0] phys(input logic [15:0] off);
        return {ss, 4'b0} + {4'b0, off};
    endfunction

    function automatic rec_t idle_rec(input logic [15:0] s, input int req);
        rec_t r;
        r = '{default: 0};
        r.spv = s; r.req = req;
        return r;
    endfunction

    function automatic void m_wr(input logic [15:0] w, input bit last, input int req);
        rec_t r;
        logic [19:0] a;
        r = idle_rec(msp, req); r.bsy = 1; r.we = 1;
        a = phys(msp - 16'd1); r.addr = a; r.wd = w[15:8];
        exp_mem[a[11:0]] = w[15:8]; q.push_back(r);
        r = idle_rec(msp, req); r.bsy = 1; r.we = 1; r.dn = last;
        a = phys(msp - 16'd2); r.addr = a; r.wd = w[7:0];
        exp_mem[a[11:0]] = w[7:0]; q.push_back(r);
        msp = msp - 16'd2;
    endfunction

    function automatic void m_rd(input logic [3:0] d, input bit wen, input bit last,
                                 input bit single, input int req);
        rec_t r;
        logic [19:0] a0, a1;
        logic [15:0] w;
        a0 = phys(msp); a1 = phys(msp + 16'd1);
        w = {exp_mem[a1[11:0]], exp_mem[a0[11:0]]};
        r = idle_rec(msp, req); r.bsy = 1; r.re = 1; r.addr = a0; q.push_back(r);
        r = idle_rec(msp, req); r.bsy = 1; r.re = 1; r.addr = a1; r.dn = last;
        r.wen = wen; r.sel = d; r.wdat = w; q.push_back(r);
        msp = (single && d == 4'd4) ? w : msp + 16'd2;
    endfunction

    task automatic issue(input logic [1:0] op, input logic [3:0] d,
                         input logic [15:0] v, input int req, input bit intrude);
        logic [15:0] s0;
        @(posedge clk); #2;
        cmd_valid = 1; cmd_op = op; cmd_dst = d; push_data = v;
        q.push_back(idle_rec(msp, req));
        s0 = msp;
        case (op)
            2'd0: m_wr(v, 1, req);
            2'd1: begin
                if (d == 4'd9 || d > 4'd11) begin
                    rec_t r;
                    r = idle_rec(msp, req); r.bsy = 1; r.ill = 1; q.push_back(r);
                end else m_rd(d, 1, 1, 1, req);
            end
            2'd2: for (int i = 0; i < 8; i++)
                      m_wr(i == 4 ? s0 : gpr_in[i*16 +: 16], i == 7, req);
            default: for (int i = 7; i >= 0; i--)
                      m_rd(4'(i), i != 4, i == 0, 0, req);
        endcase
        @(posedge clk); #2;
        if (intrude) begin
            cmd_op = 2'd1; cmd_dst = 4'd0; push_data = 16'hDEAD;
            @(posedge clk); #2;
        end
        cmd_valid = 0;
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // per-cycle comparison against the queued reference
    always @(negedge clk) begin
        if (mon_on) begin
            rec_t r;
            if (q.size() != 0) r = q.pop_front();
            else r = idle_rec(msp, 1);
            chk(busy == r.bsy, r.req, "busy", 32'(busy), 32'(r.bsy));
            chk(mem_we == r.we && mem_re == r.re, r.req, "we/re",
                {mem_we, mem_re}, {r.we, r.re});
            if (r.we || r.re) chk(mem_addr == r.addr, 4, "addr", 32'(mem_addr), 32'(r.addr));
            if (r.we) chk(mem_wdata == r.wd, r.req, "wdata", 32'(mem_wdata), 32'(r.wd));
            chk(wr_en == r.wen, r.req, "wr_en", 32'(wr_en), 32'(r.wen));
            if (r.wen) begin
                chk(wr_sel == r.sel && wr_data == r.wdat, r.req, "sel/data",
                    {wr_sel, wr_data}, {r.sel, r.wdat});
                last_pop = wr_data;
            end
            chk(done == r.dn, r.req, "done", 32'(done), 32'(r.dn));
            chk(illegal_dst == r.ill, 6, "illegal", 32'(illegal_dst), 32'(r.ill));
            chk(sp == r.spv, r.req, "sp", 32'(sp), 32'(r.spv));
        end
    end

    initial begin
        for (int i = 0; i < 4096; i++) begin mem[i] = '0; exp_mem[i] = '0; end
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(sp == 16'hFFFE, 1, "reset sp", 32'(sp), 32'hFFFE);
        chk(!busy && !done && !illegal_dst && !mem_we && !mem_re && !wr_en, 1,
            "reset strobes", {busy, done, illegal_dst, mem_we, mem_re, wr_en}, 0);
        mon_on = 1;

        // R2 pushes, R3/R5 pops in reverse order
        issue(2'd0, 0, 16'hA1B2, 2, 0);
        issue(2'd0, 0, 16'hC3D4, 2, 0);
        issue(2'd0, 0, 16'hE5F6, 2, 0);
        issue(2'd1, 4'd0, 0, 3, 0);
        chk(last_pop == 16'hE5F6, 5, "lifo first", 32'(last_pop), 32'hE5F6);
        issue(2'd1, 4'd3, 0, 3, 0);
        chk(last_pop == 16'hC3D4, 5, "lifo second", 32'(last_pop), 32'hC3D4);
        issue(2'd1, 4'd8, 0, 3, 0);
        chk(last_pop == 16'hA1B2, 5, "lifo third", 32'(last_pop), 32'hA1B2);
        chk(sp == 16'hFFFE, 3, "sp restored", 32'(sp), 32'hFFFE);

        // R6 refused destinations
        issue(2'd0, 0, 16'h7788, 2, 0);
        issue(2'd1, 4'd9, 0, 6, 0);
        issue(2'd1, 4'd13, 0, 6, 0);
        chk(sp == 16'hFFFC, 6, "sp kept", 32'(sp), 32'hFFFC);
        issue(2'd1, 4'd1, 0, 6, 0);
        chk(last_pop == 16'h7788, 6, "word intact", 32'(last_pop), 32'h7788);

        // R11 request while busy
        issue(2'd0, 0, 16'h4242, 11, 1);
        issue(2'd1, 4'd2, 0, 11, 0);
        chk(last_pop == 16'h4242, 11, "intrusion ignored", 32'(last_pop), 32'h4242);

        // R7 save-all, R8 restore-all
        for (int i = 0; i < 8; i++) gpr_in[i*16 +: 16] = 16'h1000 + 16'(i * 16'h0111);
        issue(2'd2, 0, 0, 7, 0);
        chk(sp == 16'hFFEE, 7, "sp after save", 32'(sp), 32'hFFEE);
        issue(2'd3, 0, 0, 8, 0);
        chk(sp == 16'hFFFE, 8, "sp after restore", 32'(sp), 32'hFFFE);

        // R10 load SP by pop, R9 wrap across zero
        issue(2'd0, 0, 16'h0001, 10, 0);
        issue(2'd1, 4'd4, 0, 10, 0);
        chk(sp == 16'h0001, 10, "sp loaded", 32'(sp), 32'h0001);
        issue(2'd0, 0, 16'hBEEF, 9, 0);
        chk(sp == 16'hFFFF, 9, "sp wrapped", 32'(sp), 32'hFFFF);
        issue(2'd1, 4'd2, 0, 9, 0);
        chk(last_pop == 16'hBEEF && sp == 16'h0001, 9, "wrap pop",
            {last_pop, sp}, {16'hBEEF, 16'h0001});

        // R4 high segment, physical sum overflows 20 bits
        ss = 16'hF800;
        issue(2'd0, 0, 16'h1357, 4, 0);
        issue(2'd0, 0, 16'h2468, 4, 0);
        issue(2'd1, 4'd5, 0, 4, 0);
        chk(last_pop == 16'h2468, 4, "high segment", 32'(last_pop), 32'h2468);
        issue(2'd1, 4'd6, 0, 4, 0);
        chk(last_pop == 16'h1357, 4, "high segment 2", 32'(last_pop), 32'h1357);

        repeat (3) @(negedge clk);
        mon_on = 0;
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule